// File: doc/BRIEF.md
# GPIO Interrupt Detection Unit

This unit turns eight general-purpose input lines into one combined interrupt request. Each line is configured on its own: level or edge sensitivity, detection of either edge, and an active polarity. Each qualifying event sets a bit in a raw status register. Software reads the raw status or the masked status, enables lines through a mask register, and acknowledges events by writing ones to a clear register.

The surrounding pin logic supplies the current input vector, the vector seen at the previous evaluation, and the direction vector, together with an evaluation strobe `upd_en`. Detection happens only in cycles where `upd_en` is high.

The combined request is held in a two-state machine. `IRQ_IDLE` moves to `IRQ_ACTIVE` when any masked raw status bit is 1 (transition "raise"). `IRQ_ACTIVE` returns to `IRQ_IDLE` when no masked bit is set (transition "drop"). Otherwise the state holds. `irq` is high in `IRQ_ACTIVE`.

Top module: `gpint_unit`

## Requirements
- R1: After reset the sense, both-edge, polarity, mask and raw status registers all read 0, and `irq` is low.
- R2: The 8-bit configuration registers are written and read back at these offsets: 0x404 sense (1 = level, 0 = edge), 0x408 both-edge, 0x40C polarity (1 = high/rising, 0 = low/falling), 0x410 mask.
- R3: In an evaluation cycle, an edge-mode line with its both-edge bit set and its direction bit 0 sets its raw bit if `pin_now` differs from `pin_prev` for that line. The new raw bit reads at 0x414 after that clock edge.
- R4: An edge-mode line with its both-edge bit clear sets its raw bit only when the line changed and its new value equals its polarity bit.
- R5: An edge-mode line whose direction bit is 1 never sets its raw bit.
- R6: A level-mode line sets its raw bit in every evaluation cycle where `pin_now` equals its polarity bit, whatever its direction bit. A bit cleared while that level persists is set again at the next evaluation.
- R7: Writing offset 0x41C clears exactly the raw bits written as 1 and leaves the others.
- R8: If a clear and a new event hit the same bit in the same cycle, the bit ends up set.
- R9: Offset 0x418 reads raw status AND mask.
- R10: `irq` is the OR of (raw status AND mask), registered, so it changes one cycle after the status or mask changes.
- R11: In a cycle with `upd_en` low, no raw bit is set, even when `pin_now` and `pin_prev` differ.
- R12: Writes to 0x414, 0x418 or any unlisted offset change no register. Reads of an unlisted offset return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_en | input | 1 | Evaluation strobe; detection happens only when high |
| pin_now | input | 8 | Current input value of each line |
| pin_prev | input | 8 | Input value at the previous evaluation |
| pin_dir | input | 8 | Direction per line, 1 = output |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Register byte offset for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Combined interrupt request |

## Verification
Configuration writes and status bits become visible at `rdata` right after the clock edge that captures them. `irq` follows one edge later. Inputs are driven at the falling edge. Status reads are taken at the falling edge that follows the capturing rising edge. The `irq` check waits one further falling edge. The same-cycle clear-versus-event case and the clear during a persisting level are driven at single-cycle resolution, so these ordering rules are checked exactly.

// File: rtl/gpint_pkg.sv
package gpint_pkg;
    localparam logic [11:0] OFS_SENSE = 12'h404;
    localparam logic [11:0] OFS_BOTH  = 12'h408;
    localparam logic [11:0] OFS_POL   = 12'h40C;
    localparam logic [11:0] OFS_MASK  = 12'h410;
    localparam logic [11:0] OFS_RAW   = 12'h414;
    localparam logic [11:0] OFS_MSKD  = 12'h418;
    localparam logic [11:0] OFS_CLR   = 12'h41C;

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_ACTIVE = 1'b1
    } irq_state_e;
endpackage

// File: rtl/gpint_regs.sv
module gpint_regs
    import gpint_pkg::*;
#(
    parameter int N      = 8,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N-1:0]      wdata,
    output logic [N-1:0]      sense_q,
    output logic [N-1:0]      both_q,
    output logic [N-1:0]      pol_q,
    output logic [N-1:0]      mask_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense_q <= '0;
            both_q  <= '0;
            pol_q   <= '0;
            mask_q  <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_W'(OFS_SENSE)) sense_q <= wdata;
            if (addr == ADDR_W'(OFS_BOTH))  both_q  <= wdata;
            if (addr == ADDR_W'(OFS_POL))   pol_q   <= wdata;
            if (addr == ADDR_W'(OFS_MASK))  mask_q  <= wdata;
        end
    end
endmodule

// File: rtl/gpint_detect.sv
module gpint_detect #(
    parameter int N = 8
) (
    input  logic         upd_en,
    input  logic [N-1:0] pin_now,
    input  logic [N-1:0] pin_prev,
    input  logic [N-1:0] pin_dir,
    input  logic [N-1:0] sense_q,
    input  logic [N-1:0] both_q,
    input  logic [N-1:0] pol_q,
    output logic [N-1:0] set_vec
);
    for (genvar i = 0; i < N; i++) begin : g_line
        logic match;
        logic moved;
        assign match = (pin_now[i] == pol_q[i]);
        assign moved = (pin_now[i] ^ pin_prev[i]) & ~pin_dir[i];
        always_comb begin
            if (!upd_en)         set_vec[i] = 1'b0;
            else if (sense_q[i]) set_vec[i] = match;
            else                 set_vec[i] = moved & (both_q[i] | match);
        end
    end
endmodule

// File: rtl/gpint_status.sv
module gpint_status #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] raw_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= (raw_q & ~clr_vec) | set_vec;
    end
endmodule

// File: rtl/gpint_unit.sv
module gpint_unit
    import gpint_pkg::*;
#(
    parameter int N      = 8,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [N-1:0]      pin_now,
    input  logic [N-1:0]      pin_prev,
    input  logic [N-1:0]      pin_dir,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N-1:0]      wdata,
    output logic [N-1:0]      rdata,
    output logic              irq
);
    logic [N-1:0] sense_q, both_q, pol_q, mask_q, raw_q;
    logic [N-1:0] set_vec, clr_vec;
    logic         pend;
    irq_state_e   state_q, state_d;

    gpint_regs #(.N(N), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .sense_q(sense_q), .both_q(both_q), .pol_q(pol_q), .mask_q(mask_q)
    );

    gpint_detect #(.N(N)) u_det (
        .upd_en(upd_en), .pin_now(pin_now), .pin_prev(pin_prev),
        .pin_dir(pin_dir), .sense_q(sense_q), .both_q(both_q),
        .pol_q(pol_q), .set_vec(set_vec)
    );

    assign clr_vec = (wr_en && addr == ADDR_W'(OFS_CLR)) ? wdata : '0;

    gpint_status #(.N(N)) u_stat (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
        .raw_q(raw_q)
    );

    always_comb begin
        if      (addr == ADDR_W'(OFS_SENSE)) rdata = sense_q;
        else if (addr == ADDR_W'(OFS_BOTH))  rdata = both_q;
        else if (addr == ADDR_W'(OFS_POL))   rdata = pol_q;
        else if (addr == ADDR_W'(OFS_MASK))  rdata = mask_q;
        else if (addr == ADDR_W'(OFS_RAW))   rdata = raw_q;
        else if (addr == ADDR_W'(OFS_MSKD))  rdata = raw_q & mask_q;
        else                                 rdata = '0;
    end

    assign pend = |(raw_q & mask_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (pend)  state_d = IRQ_ACTIVE;
            IRQ_ACTIVE: if (!pend) state_d = IRQ_IDLE;
            default:    state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    assign irq = (state_q == IRQ_ACTIVE);
endmodule

// File: rtl/gpint_unit_chk.sv
module gpint_unit_chk
    import gpint_pkg::*;
#(
    parameter int N      = 8,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              upd_en,
    input logic [N-1:0]      pin_now,
    input logic [N-1:0]      pin_dir,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [N-1:0]      wdata,
    input logic [N-1:0]      raw_q,
    input logic [N-1:0]      mask_q,
    input logic [N-1:0]      sense_q,
    input logic [N-1:0]      pol_q,
    input logic              irq
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (raw_q == '0 && !irq)); // R1

    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (|(raw_q & mask_q)) |=> irq); // R10

    AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(raw_q & mask_q)) |=> !irq); // R10

    AST_NO_SET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> ((raw_q & ~$past(raw_q)) == '0)); // R11

    AST_OUT_PIN_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> ((raw_q & ~$past(raw_q) & $past(pin_dir & ~sense_q)) == '0)); // R5

    AST_LEVEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> ((~raw_q & $past(sense_q & ~(pin_now ^ pol_q))) == '0)); // R6

    AST_CLR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_CLR)) |=> ((~raw_q & $past(raw_q & ~wdata)) == '0)); // R7
endmodule

bind gpint_unit gpint_unit_chk #(.N(N), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_gpint_unit.sv
module sim_gpint_unit;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_en = 1'b0;
    logic [7:0]  pin_now = '0, pin_prev = '0, pin_dir = '0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    gpint_unit u0 (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .pin_now(pin_now),
        .pin_prev(pin_prev), .pin_dir(pin_dir), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    // fields: sense, both, pol, mask, dir, prev, now, expected raw
    localparam logic [63:0] VEC [8] = '{
        {8'h00, 8'hFF, 8'h00, 8'h01, 8'h00, 8'h00, 8'h0F, 8'h0F}, // R3
        {8'h00, 8'h00, 8'hF0, 8'h0F, 8'h00, 8'h00, 8'hFF, 8'hF0}, // R4 rising
        {8'h00, 8'h00, 8'h00, 8'h80, 8'h00, 8'hFF, 8'h0F, 8'hF0}, // R4 falling
        {8'h00, 8'hFF, 8'h00, 8'hF0, 8'hF0, 8'h00, 8'hFF, 8'h0F}, // R5
        {8'hFF, 8'h00, 8'hAA, 8'hFF, 8'h00, 8'hAA, 8'hAA, 8'hFF}, // R6
        {8'h0F, 8'h00, 8'h0F, 8'h00, 8'h00, 8'h05, 8'h05, 8'h05}, // R6
        {8'h0F, 8'h00, 8'h00, 8'h0F, 8'h00, 8'h00, 8'hF0, 8'h0F}, // R6 mixed
        {8'hFF, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF}  // R6 dir=1
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic upd(input logic [7:0] d, input logic [7:0] p, input logic [7:0] n);
        @(negedge clk);
        upd_en = 1'b1; pin_dir = d; pin_prev = p; pin_now = n;
        @(negedge clk);
        upd_en = 1'b0;
    endtask

    task automatic cfg(input logic [7:0] s, input logic [7:0] b, input logic [7:0] p, input logic [7:0] m);
        wr(12'h404, s); wr(12'h408, b); wr(12'h40C, p); wr(12'h410, m);
        wr(12'h41C, 8'hFF);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(12'h404, v); check("R1 sense", v, 8'h00);
        rd(12'h408, v); check("R1 both", v, 8'h00);
        rd(12'h40C, v); check("R1 pol", v, 8'h00);
        rd(12'h410, v); check("R1 mask", v, 8'h00);
        rd(12'h414, v); check("R1 raw", v, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);

        // R2 register write/read
        wr(12'h404, 8'h3C); rd(12'h404, v); check("R2 sense", v, 8'h3C);
        wr(12'h408, 8'hA5); rd(12'h408, v); check("R2 both", v, 8'hA5);
        wr(12'h40C, 8'h96); rd(12'h40C, v); check("R2 pol", v, 8'h96);
        wr(12'h410, 8'h5A); rd(12'h410, v); check("R2 mask", v, 8'h5A);

        // table walk: R3 R4 R5 R6 R9 R10
        for (int k = 0; k < 8; k++) begin
            logic [63:0] e;
            e = VEC[k];
            pin_dir = e[31:24]; pin_prev = e[23:16]; pin_now = e[23:16];
            cfg(e[63:56], e[55:48], e[47:40], e[39:32]);
            upd(e[31:24], e[23:16], e[15:8]);
            rd(12'h414, v); check($sformatf("R3-6 vec%0d raw", k), v, e[7:0]);
            rd(12'h418, v); check($sformatf("R9 vec%0d masked", k), v, e[7:0] & e[39:32]);
            @(negedge clk);
            check($sformatf("R10 vec%0d irq", k), {7'b0, irq}, {7'b0, |(e[7:0] & e[39:32])});
        end

        // R11: no evaluation strobe, pins differ
        cfg(8'h00, 8'hFF, 8'h00, 8'hFF);
        pin_dir = 8'h00; pin_prev = 8'h00; pin_now = 8'hFF;
        repeat (3) @(negedge clk);
        rd(12'h414, v); check("R11 raw idle", v, 8'h00);

        // R7 partial clear, R10 irq drop lag
        upd(8'h00, 8'h00, 8'h0F);
        rd(12'h414, v); check("R7 raw before", v, 8'h0F);
        wr(12'h41C, 8'h05);
        rd(12'h414, v); check("R7 raw after", v, 8'h0A);
        wr(12'h410, 8'h0A);
        @(negedge clk);
        wr(12'h41C, 8'h0A);
        check("R10 irq still high", {7'b0, irq}, 8'h01);
        @(negedge clk);
        check("R10 irq low", {7'b0, irq}, 8'h00);

        // R6 persistence of level across clear
        cfg(8'h01, 8'h00, 8'h01, 8'h00);
        upd(8'h00, 8'h01, 8'h01);
        rd(12'h414, v); check("R6 level set", v, 8'h01);
        wr(12'h41C, 8'h01);
        rd(12'h414, v); check("R6 cleared", v, 8'h00);
        upd(8'h00, 8'h01, 8'h01);
        rd(12'h414, v); check("R6 reasserted", v, 8'h01);

        // R8 simultaneous clear and event
        wr(12'h41C, 8'hFF);
        @(negedge clk);
        upd_en = 1'b1; pin_now = 8'h01; pin_prev = 8'h01;
        wr_en = 1'b1; addr = 12'h41C; wdata = 8'h01;
        @(negedge clk);
        upd_en = 1'b0; wr_en = 1'b0;
        rd(12'h414, v); check("R8 set wins", v, 8'h01);

        // R12 writes to read-only / unlisted offsets
        cfg(8'h00, 8'h00, 8'h00, 8'h33);
        wr(12'h414, 8'hFF);
        wr(12'h418, 8'hFF);
        wr(12'h400, 8'hFF);
        rd(12'h414, v); check("R12 raw untouched", v, 8'h00);
        rd(12'h410, v); check("R12 mask untouched", v, 8'h33);
        rd(12'h404, v); check("R12 sense untouched", v, 8'h00);
        rd(12'h400, v); check("R12 unlisted reads 0", v, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule